// File: doc/BRIEF.md
# Translation Window Register Bank

This block is the configuration store for a bus-to-memory address translator. It keeps four address windows, each described by a base register, a mask register and a translated-base register, plus one control register. All of them are 64 bits wide. It drives every window register and the control register straight out to the translator.

Software reaches the bank through a simple request/response port. A request carries an address, a size code, a write flag and write data. The block works out the register index from the address and applies writes at the request edge. One cycle later it returns read data and an error flag. Some registers read as zero, and some accept writes and discard them. Registers that are not implemented, unknown indices and any access narrower than 64 bits set the error flag and change nothing.

Top module: `winreg_bank`

## Requirements
- R1: The register index is (req_addr - BASE_ADDR) >> 6, so each register owns a 64-byte slot and address bits [5:0] do not select anything. An address below BASE_ADDR wraps to a large index and is an error.
- R2: Size code 3 (64-bit) is the only legal size. Codes 0 (8-bit), 1 (16-bit) and 2 (32-bit) set rsp_err and leave every register unchanged.
- R3: Window base registers 0..3 sit at indices 0..3, window mask registers 0..3 at indices 4..7 and translated-base registers 0..3 at indices 8..11. Each one is fully readable and writable, and window i drives bits [64*i+63:64*i] of win_base_o, win_mask_o and xlat_base_o.
- R4: After reset every window register is zero, and the control register is 0x0000_0021_0010_0000 (bit 20 = 1, bit 32 = 1, field at bit 36 = 2).
- R5: The control register is at index 12. It is readable and writable and drives ctrl_o.
- R6: Index 13 (error status) reads as zero, and a write to it is accepted without error and discarded. Index 14 (error mask) reads as zero, and a write to it is an error.
- R7: Index 15 (invalidate all) reads as zero, and a write to it is accepted without error and has no effect.
- R8: Indices 16..21 (not implemented) and every index from 22 upward set rsp_err for reads and writes and change no register.
- R9: rsp_valid is high exactly one cycle after each req_valid cycle, and rsp_err is valid in that same cycle. rsp_rdata carries the read value and is zero for writes and for errored accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 2 | Size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Access error |
| win_base_o | output | 256 | Four window base values, window 0 in the low bits |
| win_mask_o | output | 256 | Four window mask values |
| xlat_base_o | output | 256 | Four translated-base values |
| ctrl_o | output | 64 | Control register value |

## Verification
The assertions check several things on every cycle:
- the response timing;
- that an errored response carries zero data;
- that a write of the wrong size or to an error index leaves the window and control outputs stable;
- that the control register changes only on a legal write to index 12.

Only the bench's scenarios can show the rest:
- the index map itself;
- the exact reset pattern;
- which indices read as zero or accept writes silently;
- that address bits [5:0] and addresses below the base decode as described.

// File: rtl/winreg_bank.sv
module winreg_bank #(
  parameter int          AW        = 32,
  parameter logic [AW-1:0] BASE_ADDR = 32'h8000_0000,
  parameter int          NWIN      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [1:0]          req_size,
  input  logic [63:0]         req_wdata,
  output logic                rsp_valid,
  output logic [63:0]         rsp_rdata,
  output logic                rsp_err,
  output logic [NWIN*64-1:0]  win_base_o,
  output logic [NWIN*64-1:0]  win_mask_o,
  output logic [NWIN*64-1:0]  xlat_base_o,
  output logic [63:0]         ctrl_o
);
  localparam logic [63:0] CTRL_RST = (64'd1 << 20) | (64'd1 << 32) | (64'd2 << 36);

  logic [63:0] wbase [NWIN];
  logic [63:0] wmask [NWIN];
  logic [63:0] xbase [NWIN];
  logic [63:0] ctrl_q;

  logic [AW-1:0] idx;
  logic          low_idx;
  logic [4:0]    sel;
  logic          ok;
  logic [63:0]   rval;
  logic          acc_good;
  logic          do_wr;

  assign idx      = (req_addr - BASE_ADDR) >> 6;
  assign low_idx  = (idx[AW-1:5] == '0);
  assign sel      = idx[4:0];
  assign acc_good = ok && (req_size == 2'd3);
  assign do_wr    = req_valid && req_write && acc_good;

  always_comb begin
    ok   = 1'b0;
    rval = '0;
    if (low_idx) begin
      if (sel < 5'd4) begin
        ok = 1'b1; rval = wbase[sel[1:0]];
      end else if (sel < 5'd8) begin
        ok = 1'b1; rval = wmask[sel[1:0]];
      end else if (sel < 5'd12) begin
        ok = 1'b1; rval = xbase[sel[1:0]];
      end else begin
        case (sel)
          5'd12: begin ok = 1'b1; rval = ctrl_q; end
          5'd13: ok = 1'b1;
          5'd14: ok = !req_write;
          5'd15: ok = 1'b1;
          default: ok = 1'b0;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wbase[i] <= '0;
        wmask[i] <= '0;
        xbase[i] <= '0;
      end else if (do_wr) begin
        if (sel == 5'(i))     wbase[i] <= req_wdata;
        if (sel == 5'(i + 4)) wmask[i] <= req_wdata;
        if (sel == 5'(i + 8)) xbase[i] <= req_wdata;
      end
    end
    assign win_base_o[i*64 +: 64]  = wbase[i];
    assign win_mask_o[i*64 +: 64]  = wmask[i];
    assign xlat_base_o[i*64 +: 64] = xbase[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q <= CTRL_RST;
    else if (do_wr && sel == 5'd12)    ctrl_q <= req_wdata;
  end
  assign ctrl_o = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !acc_good;
      rsp_rdata <= (req_valid && !req_write && acc_good) ? rval : 64'd0;
    end
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 64'd0));
  // R2
  bad_size_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size != 2'd3) |=>
      (rsp_err && $stable(win_base_o) && $stable(win_mask_o) &&
       $stable(xlat_base_o) && $stable(ctrl_o)));
  // R8
  err_write_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !low_idx) |=>
      (rsp_err && $stable(win_base_o) && $stable(win_mask_o) &&
       $stable(xlat_base_o) && $stable(ctrl_o)));
  // R5
  ctrl_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_size == 2'd3 && low_idx && sel == 5'd12)
      |=> $stable(ctrl_o));
endmodule

// File: tb/winreg_bank_tb.sv
module winreg_bank_tb_top;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = '0;
  logic [1:0] req_size = 2'd3;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata, ctrl_o;
  logic [255:0] win_base_o, win_mask_o, xlat_base_o;

  int total = 0, bad = 0, cycles = 0;
  logic [63:0] got_d;
  logic got_e, got_v;

  always #2.5 clk = ~clk;

  winreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .win_base_o(win_base_o), .win_mask_o(win_mask_o),
    .xlat_base_o(xlat_base_o), .ctrl_o(ctrl_o));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    got_v = rsp_valid; got_d = rsp_rdata; got_e = rsp_err;
  endtask

  function automatic logic [31:0] ra(input int idx);
    return BASE + 32'(idx * 64);
  endfunction

  task automatic t_reset;
    check("R4 ctrl_o reset", ctrl_o, CTRL_RST);
    check("R4 win_base reset", 64'(|win_base_o), 64'd0);
    check("R4 win_mask reset", 64'(|win_mask_o), 64'd0);
    check("R4 xlat_base reset", 64'(|xlat_base_o), 64'd0);
    access(0, ra(12), 2'd3, 0);
    check("R4 ctrl read reset", got_d, CTRL_RST);
    check("R9 rsp_valid", 64'(got_v), 64'd1);
    access(0, ra(5), 2'd3, 0);
    check("R4 mask1 read reset", got_d, 64'd0);
  endtask

  task automatic t_windows;
    for (int i = 0; i < 12; i++)
      access(1, ra(i), 2'd3, 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0101));
    for (int i = 0; i < 12; i++) begin
      access(0, ra(i), 2'd3, 0);
      check("R3 window readback", got_d, 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0101));
      check("R3 no error", 64'(got_e), 64'd0);
    end
    for (int i = 0; i < 4; i++) begin
      check("R3 win_base_o", win_base_o[i*64 +: 64], 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0101));
      check("R3 win_mask_o", win_mask_o[i*64 +: 64], 64'hA5A5_0000_0000_0000 ^ (64'(i+4) * 64'h0101_0101_0101));
      check("R3 xlat_base_o", xlat_base_o[i*64 +: 64], 64'hA5A5_0000_0000_0000 ^ (64'(i+8) * 64'h0101_0101_0101));
    end
    access(1, ra(2), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R9 write rdata zero", got_d, 64'd0);
    check("R3 all ones", win_base_o[128 +: 64], 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_ctrl_and_offset;
    access(1, ra(12) + 32'd8, 2'd3, 64'h1234_5678_9ABC_DEF0);
    check("R1 low bits ignored err", 64'(got_e), 64'd0);
    check("R5 ctrl_o write", ctrl_o, 64'h1234_5678_9ABC_DEF0);
    access(0, ra(12) + 32'd63, 2'd3, 0);
    check("R1 R5 ctrl read at slot end", got_d, 64'h1234_5678_9ABC_DEF0);
    access(0, BASE - 32'd64, 2'd3, 0);
    check("R1 below base err", 64'(got_e), 64'd1);
  endtask

  task automatic t_size;
    for (int s = 0; s < 3; s++) begin
      access(1, ra(0), 2'(s), 64'hDEAD);
      check("R2 narrow write err", 64'(got_e), 64'd1);
      check("R2 base0 unchanged", win_base_o[63:0], 64'hA5A5_0000_0000_0000);
      access(0, ra(12), 2'(s), 0);
      check("R2 narrow read err", 64'(got_e), 64'd1);
      check("R9 err data zero", got_d, 64'd0);
    end
  endtask

  task automatic t_raz;
    access(1, ra(13), 2'd3, 64'h55);
    check("R6 err status write ok", 64'(got_e), 64'd0);
    access(0, ra(13), 2'd3, 0);
    check("R6 err status reads zero", got_d, 64'd0);
    access(0, ra(14), 2'd3, 0);
    check("R6 err mask read zero", got_d, 64'd0);
    check("R6 err mask read ok", 64'(got_e), 64'd0);
    access(1, ra(14), 2'd3, 64'h1);
    check("R6 err mask write err", 64'(got_e), 64'd1);
    access(1, ra(15), 2'd3, 64'hFFFF);
    check("R7 invalidate write ok", 64'(got_e), 64'd0);
    check("R7 ctrl untouched", ctrl_o, 64'h1234_5678_9ABC_DEF0);
    check("R7 mask3 untouched", win_mask_o[192 +: 64], 64'hA5A5_0000_0000_0000 ^ (64'd7 * 64'h0101_0101_0101));
    access(0, ra(15), 2'd3, 0);
    check("R7 invalidate reads zero", got_d, 64'd0);
  endtask

  task automatic t_unimpl;
    for (int i = 16; i < 24; i++) begin
      access(1, ra(i), 2'd3, 64'hBEEF);
      check("R8 unimpl write err", 64'(got_e), 64'd1);
      access(0, ra(i), 2'd3, 0);
      check("R8 unimpl read err", 64'(got_e), 64'd1);
    end
    access(1, ra(32), 2'd3, 64'hBEEF);
    check("R8 index 32 err", 64'(got_e), 64'd1);
    access(1, ra(64), 2'd3, 64'hBEEF);
    check("R8 index 64 err", 64'(got_e), 64'd1);
    check("R8 base0 unchanged", win_base_o[63:0], 64'hA5A5_0000_0000_0000);
    check("R8 ctrl unchanged", ctrl_o, 64'h1234_5678_9ABC_DEF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_windows();
    t_ctrl_and_offset();
    t_size();
    t_raz();
    t_unimpl();
    @(negedge clk);
    check("R9 idle no rsp", 64'(rsp_valid), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule